// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Capacity Sharing

This block keeps in-flight work for several hardware threads in one reorder buffer of `DEPTH` entries. Each thread has its own circular queue, so its entries stay in program order. The dispatch side writes at most one entry per cycle. An entry carries a thread number, a global sequence number and a PC. Completion logic marks entries ready by thread and slot. The commit side asks to retire the front entry of one thread, and that entry leaves only once it has been marked ready.

A two-bit policy input decides how the shared capacity is offered to each thread. The choices are a fully shared limit, an equal split over the active threads, or a fixed cap taken from an input. The block reports free space for the whole buffer and for each thread, and it does not enforce the per-thread limits. It also reports the oldest front entry and the youngest back entry across the active threads, and whether any active thread can commit.

Sequence numbers are compared as plain unsigned values. Upstream hands them out in increasing order.

Top module: `rob_mt`

## Requirements
- R1: After reset, `free_o` equals `DEPTH` and every per-thread free count equals `DEPTH`. `head_valid_o`, `tail_valid_o`, `can_commit_o` and `ret_done_o` are 0.
- R2: An accepted dispatch for thread t stores its entry at slot (entries dispatched to t since reset) mod `DEPTH`. On the next cycle both `free_o` and the free count of thread t have dropped by one.
- R3: A dispatch presented while `free_o` is 0 is ignored. Occupancy, free counts and the tail stay unchanged.
- R4: The per-thread limit follows the policy and takes effect one cycle after the inputs change:
  - `policy_i`=0: the limit is `DEPTH`.
  - `policy_i`=1: the limit is `DEPTH` divided by the number of ones in `active_i`, rounded down. If no thread is active, `DEPTH`/`NT` is used.
  - `policy_i`=2: the limit is min(`thresh_i`,`DEPTH`), or `DEPTH` when exactly one thread is active.
  - `policy_i`=3: behaves as policy 0.
- R5: The free count of thread t is its limit minus its occupancy, saturating at 0. It occupies bits [t*CNT_W +: CNT_W] of `thr_free_o`.
- R6: A pulse on `rdy_valid_i` marks slot `rdy_slot_i` of thread `rdy_tid_i` ready to commit.
- R7: A retire request removes the front entry of thread `ret_tid_i` only if that thread is non-empty and its front entry is ready. Otherwise the request has no effect. On the cycle after a removal, `ret_done_o` is 1 and `ret_seq_o`/`ret_pc_o` carry the removed entry.
- R8: The head outputs give the thread number and sequence number of the lowest-numbered front entry among non-empty threads set in `active_i`. If there is no such thread, `head_valid_o` is 0.
- R9: The tail outputs give the thread number and sequence number of the highest-numbered back entry among non-empty active threads. `tail_valid_o` is 0 when there is none.
- R10: `can_commit_o` is 1 exactly when some active, non-empty thread has a ready front entry.
- R11: Queue pointers wrap modulo `DEPTH`, and per-thread order survives any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing policy select |
| active_i | input | NT | Active-thread mask |
| thresh_i | input | CNT_W | Per-thread cap for policy 2 |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tid_i | input | TID_W | Dispatch thread |
| disp_seq_i | input | SEQ_W | Dispatch sequence number |
| disp_pc_i | input | PC_W | Dispatch PC |
| rdy_valid_i | input | 1 | Mark-ready request |
| rdy_tid_i | input | TID_W | Mark-ready thread |
| rdy_slot_i | input | IDX_W | Mark-ready slot |
| ret_valid_i | input | 1 | Retire request |
| ret_tid_i | input | TID_W | Retire thread |
| ret_done_o | output | 1 | Entry retired last cycle |
| ret_seq_o | output | SEQ_W | Retired sequence number |
| ret_pc_o | output | PC_W | Retired PC |
| free_o | output | CNT_W | Global free entries |
| thr_free_o | output | NT*CNT_W | Per-thread free entries |
| can_commit_o | output | 1 | Some active front entry is ready |
| head_valid_o | output | 1 | Global head exists |
| head_tid_o | output | TID_W | Global head thread |
| head_seq_o | output | SEQ_W | Global head sequence number |
| tail_valid_o | output | 1 | Global tail exists |
| tail_tid_o | output | TID_W | Global tail thread |
| tail_seq_o | output | SEQ_W | Global tail sequence number |

## Verification
The hardest case is one where pointer wrap, a full buffer and a thread whose occupancy exceeds a shrunken limit all hold at the same time. Only a long, mixed run of dispatches and retires reaches it. The bench first sweeps every policy against every active mask on an empty buffer. It then fills the buffer to the limit and pushes extra dispatches. A seeded mix of dispatch, mark-ready and retire follows, with the policy and mask rotated during the run. A reference queue model predicts every output after each step.

// File: rtl/rob_mt_pkg.sv
package rob_mt_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_CAP    = 2'd2,
    POL_RSVD   = 2'd3
  } share_pol_e;
endpackage

// File: rtl/rob_thread_q.sv
module rob_thread_q #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             pop_i,
  input  logic             set_rdy_i,
  input  logic [IDX_W-1:0] set_idx_i,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SEQ_W-1:0] front_seq_o,
  output logic [PC_W-1:0]  front_pc_o,
  output logic             front_rdy_o,
  output logic [SEQ_W-1:0] back_seq_o
);
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [DEPTH-1:0] rdy_q;
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [IDX_W-1:0] rd_idx, wr_idx, bk_idx;

  assign rd_idx = rd_q[IDX_W-1:0];
  assign wr_idx = wr_q[IDX_W-1:0];
  assign bk_idx = wr_idx - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      rdy_q <= '0;
    end else begin
      if (push_i) begin
        wr_q          <= wr_q + PTR_W'(1);
        rdy_q[wr_idx] <= 1'b0;
      end
      if (set_rdy_i) rdy_q[set_idx_i] <= 1'b1;
      if (pop_i) rd_q <= rd_q + PTR_W'(1);
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      seq_q[wr_idx] <= seq_i;
      pc_q[wr_idx]  <= pc_i;
    end
  end

  // wrap bit separates full from empty
  assign empty_o     = (rd_q == wr_q);
  assign cnt_o       = CNT_W'(wr_q - rd_q);
  assign front_seq_o = seq_q[rd_idx];
  assign front_pc_o  = pc_q[rd_idx];
  assign front_rdy_o = rdy_q[rd_idx];
  assign back_seq_o  = seq_q[bk_idx];
endmodule

// File: rtl/rob_limit_calc.sv
module rob_limit_calc
  import rob_mt_pkg::*;
#(
  parameter int NT    = 2,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       policy_i,
  input  logic [NT-1:0]    active_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] limit_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  function automatic logic [CNT_W-1:0] share_of(input int n);
    logic [CNT_W-1:0] r;
    r = CNT_W'(DEPTH / NT);
    for (int k = 1; k <= NT; k++) begin
      if (n == k) r = CNT_W'(DEPTH / k);
    end
    return r;
  endfunction

  int               n_act;
  logic [CNT_W-1:0] cap;
  share_pol_e       pol;

  always_comb begin
    n_act = 0;
    for (int t = 0; t < NT; t++) n_act += int'(active_i[t]);
  end

  assign pol = share_pol_e'(policy_i);
  assign cap = (thresh_i > FULL) ? FULL : thresh_i;

  always_comb begin
    unique case (pol)
      POL_SPLIT: limit_o = share_of(n_act);
      POL_CAP:   limit_o = (n_act == 1) ? FULL : cap;
      default:   limit_o = FULL;
    endcase
  end
endmodule

// File: rtl/rob_age_sel.sv
module rob_age_sel #(
  parameter int NT       = 2,
  parameter int SEQ_W    = 8,
  parameter bit PICK_MAX = 1'b0,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0]       cand_i,
  input  logic [NT*SEQ_W-1:0] seq_i,
  output logic                valid_o,
  output logic [TID_W-1:0]    tid_o,
  output logic [SEQ_W-1:0]    seq_o
);
  logic [SEQ_W-1:0] s [NT];
  logic [NT-1:0]    beats [NT];

  // pairwise comparators; direction chosen by PICK_MAX
  for (genvar a = 0; a < NT; a++) begin : g_unpack
    assign s[a] = seq_i[a*SEQ_W +: SEQ_W];
  end

  for (genvar a = 0; a < NT; a++) begin : g_row
    for (genvar b = 0; b < NT; b++) begin : g_col
      if (PICK_MAX) begin : g_max
        assign beats[a][b] = (s[a] > s[b]) || ((s[a] == s[b]) && (a < b));
      end else begin : g_min
        assign beats[a][b] = (s[a] < s[b]) || ((s[a] == s[b]) && (a < b));
      end
    end
  end

  logic [NT-1:0] win;
  always_comb begin
    for (int a = 0; a < NT; a++) begin
      win[a] = cand_i[a];
      for (int b = 0; b < NT; b++) begin
        if (b != a && cand_i[b] && !beats[a][b]) win[a] = 1'b0;
      end
    end
  end

  always_comb begin
    valid_o = |cand_i;
    tid_o   = '0;
    seq_o   = '0;
    for (int a = 0; a < NT; a++) begin
      if (win[a]) begin
        tid_o = TID_W'(a);
        seq_o = s[a];
      end
    end
  end
endmodule

// File: rtl/rob_mt.sv
module rob_mt #(
  parameter int NT    = 2,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          policy_i,
  input  logic [NT-1:0]       active_i,
  input  logic [CNT_W-1:0]    thresh_i,
  input  logic                disp_valid_i,
  input  logic [TID_W-1:0]    disp_tid_i,
  input  logic [SEQ_W-1:0]    disp_seq_i,
  input  logic [PC_W-1:0]     disp_pc_i,
  input  logic                rdy_valid_i,
  input  logic [TID_W-1:0]    rdy_tid_i,
  input  logic [IDX_W-1:0]    rdy_slot_i,
  input  logic                ret_valid_i,
  input  logic [TID_W-1:0]    ret_tid_i,
  output logic                ret_done_o,
  output logic [SEQ_W-1:0]    ret_seq_o,
  output logic [PC_W-1:0]     ret_pc_o,
  output logic [CNT_W-1:0]    free_o,
  output logic [NT*CNT_W-1:0] thr_free_o,
  output logic                can_commit_o,
  output logic                head_valid_o,
  output logic [TID_W-1:0]    head_tid_o,
  output logic [SEQ_W-1:0]    head_seq_o,
  output logic                tail_valid_o,
  output logic [TID_W-1:0]    tail_tid_o,
  output logic [SEQ_W-1:0]    tail_seq_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [NT-1:0]       q_empty, q_rdy, q_push, q_pop, q_set;
  logic [CNT_W-1:0]    q_cnt  [NT];
  logic [SEQ_W-1:0]    q_fseq [NT];
  logic [PC_W-1:0]     q_fpc  [NT];
  logic [NT*SEQ_W-1:0] fseq_flat, bseq_flat;
  logic [CNT_W-1:0]    tot_q, limit_q, limit_d;
  logic                disp_ok, ret_ok;

  assign disp_ok = disp_valid_i && (tot_q != FULL);
  assign ret_ok  = ret_valid_i && !q_empty[ret_tid_i] && q_rdy[ret_tid_i];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [SEQ_W-1:0] bseq;

    assign q_push[t] = disp_ok && (disp_tid_i == TID_W'(t));
    assign q_pop[t]  = ret_ok && (ret_tid_i == TID_W'(t));
    assign q_set[t]  = rdy_valid_i && (rdy_tid_i == TID_W'(t));

    rob_thread_q #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (q_push[t]),
      .seq_i       (disp_seq_i),
      .pc_i        (disp_pc_i),
      .pop_i       (q_pop[t]),
      .set_rdy_i   (q_set[t]),
      .set_idx_i   (rdy_slot_i),
      .empty_o     (q_empty[t]),
      .cnt_o       (q_cnt[t]),
      .front_seq_o (q_fseq[t]),
      .front_pc_o  (q_fpc[t]),
      .front_rdy_o (q_rdy[t]),
      .back_seq_o  (bseq)
    );

    assign fseq_flat[t*SEQ_W +: SEQ_W] = q_fseq[t];
    assign bseq_flat[t*SEQ_W +: SEQ_W] = bseq;
    // limit can drop below occupancy after a policy change
    assign thr_free_o[t*CNT_W +: CNT_W] =
      (limit_q > q_cnt[t]) ? (limit_q - q_cnt[t]) : '0;
  end

  rob_limit_calc #(.NT(NT), .DEPTH(DEPTH)) u_lim (
    .policy_i (policy_i),
    .active_i (active_i),
    .thresh_i (thresh_i),
    .limit_o  (limit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q      <= '0;
      limit_q    <= FULL;
      ret_done_o <= 1'b0;
      ret_seq_o  <= '0;
      ret_pc_o   <= '0;
    end else begin
      limit_q    <= limit_d;
      tot_q      <= tot_q + CNT_W'(disp_ok) - CNT_W'(ret_ok);
      ret_done_o <= ret_ok;
      if (ret_ok) begin
        ret_seq_o <= q_fseq[ret_tid_i];
        ret_pc_o  <= q_fpc[ret_tid_i];
      end
    end
  end

  logic [NT-1:0] live;
  assign live         = active_i & ~q_empty;
  assign free_o       = FULL - tot_q;
  assign can_commit_o = |(live & q_rdy);

  rob_age_sel #(.NT(NT), .SEQ_W(SEQ_W), .PICK_MAX(1'b0)) u_head (
    .cand_i  (live),
    .seq_i   (fseq_flat),
    .valid_o (head_valid_o),
    .tid_o   (head_tid_o),
    .seq_o   (head_seq_o)
  );

  rob_age_sel #(.NT(NT), .SEQ_W(SEQ_W), .PICK_MAX(1'b1)) u_tail (
    .cand_i  (live),
    .seq_i   (bseq_flat),
    .valid_o (tail_valid_o),
    .tid_o   (tail_tid_o),
    .seq_o   (tail_seq_o)
  );
endmodule

// File: rtl/rob_mt_chk.sv
module rob_mt_chk #(
  parameter int CNT_W = 4,
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             ret_valid_i,
  input logic             ret_done_o,
  input logic [CNT_W-1:0] free_o,
  input logic             can_commit_o,
  input logic             head_valid_o,
  input logic             tail_valid_o,
  input logic [SEQ_W-1:0] head_seq_o,
  input logic [SEQ_W-1:0] tail_seq_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_o == '0 && !ret_valid_i) |=> (free_o == '0)); // R3

  AST_DISP_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && free_o != '0 && !ret_valid_i) |=> (free_o == $past(free_o) - CNT_W'(1))); // R2

  AST_RET_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_done_o && !$past(disp_valid_i)) |-> (free_o == $past(free_o) + CNT_W'(1))); // R7

  AST_ENDS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o == tail_valid_o); // R9

  AST_HEAD_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o |-> (head_seq_o <= tail_seq_o)); // R8

  AST_COMMIT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_o |-> !can_commit_o); // R10
endmodule

bind rob_mt rob_mt_chk #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .ret_valid_i  (ret_valid_i),
  .ret_done_o   (ret_done_o),
  .free_o       (free_o),
  .can_commit_o (can_commit_o),
  .head_valid_o (head_valid_o),
  .tail_valid_o (tail_valid_o),
  .head_seq_o   (head_seq_o),
  .tail_seq_o   (tail_seq_o)
);

// File: tb/rob_mt_tb_top.sv
`timescale 1ns/1ps
module rob_mt_tb_top;
  localparam int NT = 2, DEPTH = 8, CNT_W = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] policy_i = 2'd0;
  logic [1:0] active_i = 2'b11;
  logic [3:0] thresh_i = 4'd3;
  logic       disp_valid_i = 0, disp_tid_i = 0;
  logic [7:0] disp_seq_i = 0, disp_pc_i = 0;
  logic       rdy_valid_i = 0, rdy_tid_i = 0;
  logic [2:0] rdy_slot_i = 0;
  logic       ret_valid_i = 0, ret_tid_i = 0;
  logic       ret_done_o, can_commit_o, head_valid_o, tail_valid_o;
  logic       head_tid_o, tail_tid_o;
  logic [7:0] ret_seq_o, ret_pc_o, head_seq_o, tail_seq_o;
  logic [3:0] free_o;
  logic [7:0] thr_free_o;

  rob_mt dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mseq [2][8];
  bit   mrdy [2][8];
  int   wp [2], rp [2], cnt [2];
  int   mtot = 0;
  logic [7:0] sn = 8'd1;
  int   lcg = 12345;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim();
    int n = int'(active_i[0]) + int'(active_i[1]);
    case (policy_i)
      2'd1: return (n == 0) ? DEPTH / NT : DEPTH / n;
      2'd2: return (n == 1) ? DEPTH : ((thresh_i > DEPTH) ? DEPTH : int'(thresh_i));
      default: return DEPTH;
    endcase
  endfunction

  task automatic check_all(input string tag);
    int hv = 0, ht = 0, hs = 0, tv = 0, tt = 0, ts = 0, cc = 0;
    chk(int'(free_o) == DEPTH - mtot, {tag, " R2 global free"}, free_o, DEPTH - mtot);
    for (int t = 0; t < NT; t++) begin
      int l = lim();
      int e = (l > cnt[t]) ? l - cnt[t] : 0;
      chk(int'(thr_free_o[t*CNT_W +: CNT_W]) == e, {tag, " R5 thread free"},
          thr_free_o[t*CNT_W +: CNT_W], e);
      if (active_i[t] && cnt[t] > 0) begin
        int f = mseq[t][rp[t]];
        int b = mseq[t][(wp[t] + 7) % 8];
        if (!hv || f < hs) begin hv = 1; ht = t; hs = f; end
        if (!tv || b > ts) begin tv = 1; tt = t; ts = b; end
        if (mrdy[t][rp[t]]) cc = 1;
      end
    end
    chk(int'(head_valid_o) == hv, {tag, " R8 head valid"}, head_valid_o, hv);
    if (hv) chk(int'(head_tid_o) == ht && int'(head_seq_o) == hs, {tag, " R8 head seq"},
                head_seq_o, hs);
    chk(int'(tail_valid_o) == tv, {tag, " R9 tail valid"}, tail_valid_o, tv);
    if (tv) chk(int'(tail_tid_o) == tt && int'(tail_seq_o) == ts, {tag, " R9 tail seq"},
                tail_seq_o, ts);
    chk(int'(can_commit_o) == cc, {tag, " R10 can commit"}, can_commit_o, cc);
  endtask

  task automatic do_disp(input int t);
    disp_valid_i = 1; disp_tid_i = t[0]; disp_seq_i = sn; disp_pc_i = sn ^ 8'hA5;
    @(negedge clk_i);
    disp_valid_i = 0;
    if (mtot < DEPTH) begin
      mseq[t][wp[t]] = sn; mrdy[t][wp[t]] = 0;
      wp[t] = (wp[t] + 1) % 8; cnt[t]++; mtot++;
    end
    sn++;
  endtask

  task automatic do_rdy(input int t, input int slot);
    rdy_valid_i = 1; rdy_tid_i = t[0]; rdy_slot_i = slot[2:0];
    @(negedge clk_i);
    rdy_valid_i = 0;
    mrdy[t][slot] = 1;
  endtask

  task automatic do_ret(input int t, input string tag);
    bit ok = (cnt[t] > 0) && mrdy[t][rp[t]];
    int es = mseq[t][rp[t]];
    ret_valid_i = 1; ret_tid_i = t[0];
    @(negedge clk_i);
    ret_valid_i = 0;
    chk(ret_done_o == ok, {tag, " R7 retire done"}, ret_done_o, ok);
    if (ok) begin
      chk(int'(ret_seq_o) == es && ret_pc_o == (es[7:0] ^ 8'hA5), {tag, " R7 retire seq"},
          ret_seq_o, es);
      rp[t] = (rp[t] + 1) % 8; cnt[t]--; mtot--;
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      wp[t] = 0; rp[t] = 0; cnt[t] = 0;
      for (int s = 0; s < 8; s++) begin mseq[t][s] = 0; mrdy[t][s] = 0; end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(free_o == 4'd8, "R1 free", free_o, 8);
    chk(thr_free_o == 8'h88, "R1 thread free", thr_free_o, 8'h88);
    chk(!head_valid_o && !tail_valid_o, "R1 ends invalid", head_valid_o, 0);
    chk(!can_commit_o && !ret_done_o, "R1 commit idle", can_commit_o, 0);

    // R4 sweep of policy against active mask
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        policy_i = p[1:0]; active_i = m[1:0];
        settle();
        for (int t = 0; t < NT; t++)
          chk(int'(thr_free_o[t*CNT_W +: CNT_W]) == lim(), "R4 limit",
              thr_free_o[t*CNT_W +: CNT_W], lim());
      end
    end
    policy_i = 0; active_i = 2'b11; settle();

    // R2 interleaved dispatch
    do_disp(0); check_all("disp");
    do_disp(1); check_all("disp");
    do_disp(0); check_all("disp");
    do_disp(1); check_all("disp");
    do_disp(1); check_all("disp");

    // R7 retire without ready has no effect
    do_ret(0, "notready"); check_all("notready");
    do_rdy(1, 0); check_all("R6 ready");
    do_ret(0, "other"); check_all("other");
    do_ret(1, "ready"); check_all("ready");

    // R8 R9 active mask exclusion
    active_i = 2'b01; settle(); check_all("mask01");
    active_i = 2'b10; settle(); check_all("mask10");
    active_i = 2'b11; settle();

    // R3 fill then overflow
    for (int i = 0; i < 6; i++) begin do_disp(i % 2); check_all("fill"); end
    do_disp(0); check_all("R3 over");
    do_disp(1); check_all("R3 over");

    // R5 limit below occupancy
    policy_i = 2'd1; settle(); check_all("split");
    policy_i = 2'd2; settle(); check_all("cap");

    // R11 mixed traffic with wrap
    for (int i = 0; i < 400; i++) begin
      int op, t;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      op = (lcg >> 8) % 4; t = (lcg >> 4) & 1;
      if (i % 50 == 49) begin
        policy_i = policy_i + 2'd1;
        active_i = (active_i == 2'b11) ? 2'b01 : active_i + 2'b01;
      end
      case (op)
        0, 1: do_disp(t);
        2: do_rdy(t, (rp[t] + ((cnt[t] > 0) ? ((lcg >> 12) % cnt[t]) : 0)) % 8);
        default: do_ret(t, "R11 mix");
      endcase
      check_all("R11 mix");
    end

    // drain everything in global order
    policy_i = 0; active_i = 2'b11; settle();
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < 8; s++) do_rdy(t, s);
    while (mtot > 0) begin
      do_ret((cnt[0] > 0) ? 0 : 1, "drain");
      check_all("drain");
    end
    chk(!head_valid_o && free_o == 4'd8, "R8 empty head", head_valid_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule